// File: doc/BRIEF.md
# Horizontal PLL Phase Detector Mode Controller

This block decides how the first horizontal phase-locked loop behaves from one moment to the next. It takes a measured signal-to-noise figure, the loop's coincidence (lock) flag, a vertical-retrace flag and a flag for a Y/C source whose chroma input is tied to ground. From these it produces three outputs: a slow/fast loop-speed flag, a 9-bit charge-current code in microamps for the analog phase detector, and an enable gate for that detector.

A noisy input selects slow mode. In slow mode a locked loop uses a small fixed current, and the detector is enabled only inside a short window centred on the expected sync edge. A line-period flywheel counter tracks that edge. A clean input, or a loop that has lost lock, uses the normal current during scan and 50 % more during vertical retrace, with the detector always enabled. The speed decision uses hysteresis and is taken once per field, at the end of retrace. The Y/C-grounded condition overrides the decision to fast at once.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `hpll_pd_mode_ctrl`

## Requirements
- R1: After reset `loop_slow` is 0, the flywheel phase is 0, and with `sync_locked` low `pd_current` is 180 and `pd_gate` is 1.
- R2: While `sync_locked` is 0, `pd_current` is 180 with `vretrace` low and 270 with `vretrace` high, and `pd_gate` is 1, whatever the speed mode.
- R3: While `sync_locked` is 1 and `loop_slow` is 0, `pd_current` is 180 outside retrace and 270 during retrace, and `pd_gate` is 1.
- R4: While `sync_locked` is 1 and `loop_slow` is 1, `pd_current` is 30 both during scan and during retrace.
- R5: A retrace end is the first clock edge at which `vretrace` is sampled 0 after being sampled 1. If `snr_db` < SNR_ENTER (default 20) at that edge and `yc_chroma_gnd` is low, `loop_slow` rises on that edge.
- R6: In slow mode, a retrace end with `snr_db` >= SNR_ENTER+SNR_HYST (default 23) returns `loop_slow` to 0. Values from 20 to 22 leave the mode unchanged in either direction.
- R7: A change of `snr_db` away from a retrace end has no effect on `loop_slow`.
- R8: `yc_chroma_gnd` high clears `loop_slow` on the next edge and keeps it clear, even when a retrace end with low `snr_db` falls in that cycle.
- R9: An `hsync_start` edge sets the flywheel phase to 0. In slow locked mode `pd_gate` is 1 only at phases below GATE_CYCLES-GATE_CYCLES/2 and at phases of LINE_CYCLES-GATE_CYCLES/2 or more. This gives GATE_CYCLES open cycles per line, centred on the sync edge.
- R10: Without `hsync_start` the phase wraps from LINE_CYCLES-1 to 0, so the gate window repeats every LINE_CYCLES clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_start | input | 1 | One-cycle strobe at the front edge of a separated sync |
| sync_locked | input | 1 | Coincidence detector reports lock |
| snr_db | input | SNR_W | Measured signal-to-noise ratio in dB, unsigned |
| vretrace | input | 1 | Vertical retrace interval in progress |
| yc_chroma_gnd | input | 1 | Y/C mode with chroma input grounded |
| loop_slow | output | 1 | 1 = slow (weak-signal) loop time constant |
| pd_current | output | 9 | Phase detector current code in µA |
| pd_gate | output | 1 | Phase detector enable |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the once-per-field speed decision and the Y/C-grounded override. The bench raises `yc_chroma_gnd` on exactly the edge where a low-SNR retrace end is detected, and judges correct behaviour as `loop_slow` staying 0 with the locked current at 180. The second pair is a sync strobe and the flywheel wrap. The bench leaves the counter free-running across several wraps, then strobes, and sweeps the gate cycle by cycle against the phase computed from the strobe position.

// File: rtl/hpll_pd_pkg.sv
package hpll_pd_pkg;
  typedef enum logic {
    LOOP_FAST = 1'b0,
    LOOP_SLOW = 1'b1
  } loop_mode_e;

  localparam int unsigned CUR_W = 9;
  typedef logic [CUR_W-1:0] pd_cur_t;
endpackage

// File: rtl/hpll_pd_noise_hyst.sv
// Speed-mode register: hysteresis on SNR, evaluated at retrace end,
// overridden to fast by the Y/C-grounded condition.
module hpll_pd_noise_hyst
  import hpll_pd_pkg::*;
#(
  parameter int SNR_W     = 8,
  parameter int SNR_ENTER = 20,
  parameter int SNR_HYST  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vretrace,
  input  logic             yc_force,
  input  logic [SNR_W-1:0] snr_db,
  output loop_mode_e       mode_o
);
  localparam int SNR_EXIT = SNR_ENTER + SNR_HYST;

  logic       vr_q;
  loop_mode_e mode_q;
  logic       field_end;
  logic       too_noisy;
  logic       clean_enough;

  assign field_end    = vr_q & ~vretrace;
  assign too_noisy    = int'(snr_db) < SNR_ENTER;
  assign clean_enough = int'(snr_db) >= SNR_EXIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vr_q   <= 1'b0;
      mode_q <= LOOP_FAST;
    end else begin
      vr_q <= vretrace;
      if (yc_force) begin
        mode_q <= LOOP_FAST;
      end else if (field_end) begin
        unique case (mode_q)
          LOOP_FAST: if (too_noisy)    mode_q <= LOOP_SLOW;
          LOOP_SLOW: if (clean_enough) mode_q <= LOOP_FAST;
          default:                     mode_q <= LOOP_FAST;
        endcase
      end
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/hpll_pd_line_window.sv
// Line-period flywheel and the gate window centred on the expected sync.
module hpll_pd_line_window #(
  parameter int LINE_CYCLES = 6400,
  parameter int GATE_CYCLES = 570
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_strobe,
  output logic win_o
);
  localparam int CNT_W     = (LINE_CYCLES > 2) ? $clog2(LINE_CYCLES) : 1;
  localparam int GATE_PRE  = GATE_CYCLES / 2;
  localparam int GATE_POST = GATE_CYCLES - GATE_PRE;
  localparam int OPEN_AT   = LINE_CYCLES - GATE_PRE;

  logic [CNT_W-1:0] phase_q;
  logic             wrap;
  logic             early_part;
  logic             late_part;

  assign wrap = (phase_q == CNT_W'(LINE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (sync_strobe || wrap) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  generate
    if (GATE_POST > 0) begin : g_post
      assign early_part = phase_q < CNT_W'(GATE_POST);
    end else begin : g_no_post
      assign early_part = 1'b0;
    end
    if (GATE_PRE > 0) begin : g_pre
      assign late_part = phase_q >= CNT_W'(OPEN_AT);
    end else begin : g_no_pre
      assign late_part = 1'b0;
    end
  endgenerate

  assign win_o = early_part | late_part;
endmodule

// File: rtl/hpll_pd_current_sel.sv
// Picks the current code and the detector enable from mode and lock.
module hpll_pd_current_sel
  import hpll_pd_pkg::*;
#(
  parameter int I_WEAK    = 30,
  parameter int I_SCAN    = 180,
  parameter int I_RETRACE = 270
) (
  input  loop_mode_e mode,
  input  logic       locked,
  input  logic       vretrace,
  input  logic       win,
  output pd_cur_t    cur_o,
  output logic       gate_o
);
  logic weak_locked;

  assign weak_locked = locked && (mode == LOOP_SLOW);

  always_comb begin
    if (weak_locked) begin
      cur_o  = CUR_W'(I_WEAK);
      gate_o = win;
    end else begin
      cur_o  = vretrace ? CUR_W'(I_RETRACE) : CUR_W'(I_SCAN);
      gate_o = 1'b1;
    end
  end
endmodule

// File: rtl/hpll_pd_mode_ctrl.sv
module hpll_pd_mode_ctrl
  import hpll_pd_pkg::*;
#(
  parameter int LINE_CYCLES = 6400,
  parameter int GATE_CYCLES = 570,
  parameter int SNR_W       = 8,
  parameter int SNR_ENTER   = 20,
  parameter int SNR_HYST    = 3,
  parameter int I_WEAK      = 30,
  parameter int I_SCAN      = 180,
  parameter int I_RETRACE   = 270
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           hsync_start,
  input  logic                           sync_locked,
  input  logic [SNR_W-1:0]               snr_db,
  input  logic                           vretrace,
  input  logic                           yc_chroma_gnd,
  output logic                           loop_slow,
  output logic [hpll_pd_pkg::CUR_W-1:0]  pd_current,
  output logic                           pd_gate
);
  loop_mode_e mode;
  logic       win;

  hpll_pd_noise_hyst #(
    .SNR_W    (SNR_W),
    .SNR_ENTER(SNR_ENTER),
    .SNR_HYST (SNR_HYST)
  ) u_hyst (
    .clk     (clk),
    .rst_n   (rst_n),
    .vretrace(vretrace),
    .yc_force(yc_chroma_gnd),
    .snr_db  (snr_db),
    .mode_o  (mode)
  );

  hpll_pd_line_window #(
    .LINE_CYCLES(LINE_CYCLES),
    .GATE_CYCLES(GATE_CYCLES)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_strobe(hsync_start),
    .win_o      (win)
  );

  hpll_pd_current_sel #(
    .I_WEAK   (I_WEAK),
    .I_SCAN   (I_SCAN),
    .I_RETRACE(I_RETRACE)
  ) u_sel (
    .mode    (mode),
    .locked  (sync_locked),
    .vretrace(vretrace),
    .win     (win),
    .cur_o   (pd_current),
    .gate_o  (pd_gate)
  );

  assign loop_slow = (mode == LOOP_SLOW);
endmodule

// File: rtl/hpll_pd_mode_chk.sv
module hpll_pd_mode_chk #(
  parameter int SNR_W     = 8,
  parameter int SNR_ENTER = 20,
  parameter int SNR_HYST  = 3,
  parameter int I_WEAK    = 30,
  parameter int I_SCAN    = 180,
  parameter int I_RETRACE = 270
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync_start,
  input logic             sync_locked,
  input logic [SNR_W-1:0] snr_db,
  input logic             vretrace,
  input logic             yc_chroma_gnd,
  input logic             loop_slow,
  input logic [8:0]       pd_current,
  input logic             pd_gate
);
  // R2
  unlocked_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_locked |-> pd_gate && (int'(pd_current) == (vretrace ? I_RETRACE : I_SCAN)));

  // R3
  fast_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_locked && !loop_slow) |-> pd_gate && (int'(pd_current) == (vretrace ? I_RETRACE : I_SCAN)));

  // R4
  weak_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_locked && loop_slow) |-> int'(pd_current) == I_WEAK);

  // R5
  slow_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_slow) |-> ($past(vretrace, 2) && !$past(vretrace) &&
                          int'($past(snr_db)) < SNR_ENTER && !$past(yc_chroma_gnd)));

  // R6
  slow_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loop_slow) |-> ($past(yc_chroma_gnd) ||
                          ($past(vretrace, 2) && !$past(vretrace) &&
                           int'($past(snr_db)) >= SNR_ENTER + SNR_HYST)));

  // R8
  yc_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yc_chroma_gnd |=> !loop_slow);

  // R9
  gate_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hsync_start) && sync_locked && loop_slow) |-> pd_gate);
endmodule

bind hpll_pd_mode_ctrl hpll_pd_mode_chk #(
  .SNR_W    (SNR_W),
  .SNR_ENTER(SNR_ENTER),
  .SNR_HYST (SNR_HYST),
  .I_WEAK   (I_WEAK),
  .I_SCAN   (I_SCAN),
  .I_RETRACE(I_RETRACE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hsync_start  (hsync_start),
  .sync_locked  (sync_locked),
  .snr_db       (snr_db),
  .vretrace     (vretrace),
  .yc_chroma_gnd(yc_chroma_gnd),
  .loop_slow    (loop_slow),
  .pd_current   (pd_current),
  .pd_gate      (pd_gate)
);

// File: tb/hpll_pd_mode_ctrl_tb.sv
`timescale 1ns/1ps
module hpll_pd_mode_ctrl_tb;
  localparam int LINE = 40;
  localparam int GATE = 7;
  localparam int PRE  = GATE / 2;
  localparam int POST = GATE - PRE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_start = 1'b0;
  logic       sync_locked = 1'b0;
  logic [7:0] snr_db = 8'd40;
  logic       vretrace = 1'b0;
  logic       yc_chroma_gnd = 1'b0;
  logic       loop_slow;
  logic [8:0] pd_current;
  logic       pd_gate;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  hpll_pd_mode_ctrl #(
    .LINE_CYCLES(LINE),
    .GATE_CYCLES(GATE)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hsync_start  (hsync_start),
    .sync_locked  (sync_locked),
    .snr_db       (snr_db),
    .vretrace     (vretrace),
    .yc_chroma_gnd(yc_chroma_gnd),
    .loop_slow    (loop_slow),
    .pd_current   (pd_current),
    .pd_gate      (pd_gate)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One field end: retrace for three cycles, then the falling edge.
  task automatic run_field(int snr);
    snr_db = 8'(snr);
    vretrace = 1'b1;
    repeat (3) tick();
    vretrace = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    check("R1 slow", int'(loop_slow), 0);
    check("R1 current", int'(pd_current), 180);
    check("R1 gate", int'(pd_gate), 1);
  endtask

  task automatic t_unlocked();
    sync_locked = 1'b0;
    vretrace = 1'b0; tick();
    check("R2 scan current", int'(pd_current), 180);
    vretrace = 1'b1; tick();
    check("R2 retrace current", int'(pd_current), 270);
    check("R2 gate", int'(pd_gate), 1);
    vretrace = 1'b0; tick();
  endtask

  task automatic t_fast_locked();
    sync_locked = 1'b1;
    run_field(40);
    check("R3 mode", int'(loop_slow), 0);
    check("R3 scan current", int'(pd_current), 180);
    vretrace = 1'b1; tick();
    check("R3 retrace current", int'(pd_current), 270);
    check("R3 gate", int'(pd_gate), 1);
    vretrace = 1'b0; tick();
  endtask

  task automatic t_enter();
    run_field(15);
    check("R5 enter slow", int'(loop_slow), 1);
    check("R4 scan current", int'(pd_current), 30);
    vretrace = 1'b1; tick();
    check("R4 retrace current", int'(pd_current), 30);
    vretrace = 1'b0; tick();
  endtask

  task automatic t_hyst();
    run_field(21);
    check("R6 hold slow at 21", int'(loop_slow), 1);
    run_field(22);
    check("R6 hold slow at 22", int'(loop_slow), 1);
    run_field(23);
    check("R6 exit at 23", int'(loop_slow), 0);
    run_field(22);
    check("R6 hold fast at 22", int'(loop_slow), 0);
    run_field(20);
    check("R6 hold fast at 20", int'(loop_slow), 0);
    run_field(19);
    check("R5 enter at 19", int'(loop_slow), 1);
  endtask

  task automatic t_midfield();
    snr_db = 8'd60;
    repeat (20) tick();
    check("R7 slow kept mid-field", int'(loop_slow), 1);
    run_field(10);
    check("R7 slow after low field", int'(loop_slow), 1);
    snr_db = 8'd5;
    run_field(40);
    check("R6 fast after clean field", int'(loop_slow), 0);
    snr_db = 8'd5;
    repeat (20) tick();
    check("R7 fast kept mid-field", int'(loop_slow), 0);
    run_field(10);
    check("R5 slow again", int'(loop_slow), 1);
  endtask

  task automatic t_gate();
    sync_locked = 1'b1;
    hsync_start = 1'b1;
    tick();
    hsync_start = 1'b0;
    for (int k = 0; k < 2 * LINE; k++) begin
      automatic int ph = k % LINE;
      automatic int exp = (ph < POST || ph >= LINE - PRE) ? 1 : 0;
      if (k >= LINE) check("R10 flywheel gate", int'(pd_gate), exp);
      else           check("R9 gate window", int'(pd_gate), exp);
      tick();
    end
    sync_locked = 1'b0;
    tick();
    check("R2 gate open unlocked in slow", int'(pd_gate), 1);
    check("R2 current unlocked in slow", int'(pd_current), 180);
    sync_locked = 1'b1;
    tick();
  endtask

  task automatic t_yc();
    check("R8 pre-state slow", int'(loop_slow), 1);
    yc_chroma_gnd = 1'b1;
    tick();
    check("R8 forced fast", int'(loop_slow), 0);
    check("R8 current", int'(pd_current), 180);
    // low-SNR retrace end with the override active on the same edge
    yc_chroma_gnd = 1'b0;
    snr_db = 8'd5;
    vretrace = 1'b1;
    repeat (3) tick();
    vretrace = 1'b0;
    yc_chroma_gnd = 1'b1;
    tick();
    check("R8 override wins at field end", int'(loop_slow), 0);
    check("R8 current at field end", int'(pd_current), 180);
    yc_chroma_gnd = 1'b0;
    repeat (5) tick();
    check("R8 stays fast until field end", int'(loop_slow), 0);
    run_field(5);
    check("R5 slow after override drops", int'(loop_slow), 1);
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_unlocked();
    t_fast_locked();
    t_enter();
    t_hyst();
    t_midfield();
    t_gate();
    t_yc();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule